// File: doc/BRIEF.md
# Predicated Whole-Vector Left Shift with Scalar Carry

This block shifts a 128-bit vector left as four chained 32-bit lanes. A 32-bit scalar carry value feeds bits into the bottom of lane 0. Each enabled lane passes the bits it shifts out on to the next lane as its carry. The carry that leaves lane 3 becomes the new scalar value, and that value is written back to the register that supplied the incoming carry.

A 16-bit byte predicate controls the operation. Each byte of the result is written only where its predicate bit is set, and the predicate bit at the bottom byte of a lane decides whether that lane advances the carry chain. A shift immediate of zero means a full 32-bit shift. A scalar register index naming the stack pointer slot (13) or the program counter slot (15) is rejected.

The datapath is combinational. Its outputs are registered once behind a valid strobe.

Top module: `vshc_unit`

## Requirements
- R1: For a shift immediate s from 1 to 31, the raw result of lane e is the lane's 32-bit element shifted left by s, ORed with the low s bits of the carry that enters that lane. Lane e holds vector bits [32e+31:32e], and lane 0 receives `carry_in`.
- R2: When lane e is enabled, the carry it passes onward is that element's original top s bits, right-aligned with zeros above them.
- R3: When lane e is disabled, the carry passes through that lane unchanged. Lane e is enabled by `pred[4e]`.
- R4: An immediate of 0 means a shift of 32. The raw result of the lane is the incoming carry, and an enabled lane passes its whole original element onward as the carry.
- R5: Output byte b (vector bits [8b+7:8b]) takes the raw result byte when `pred[b]` is 1. Otherwise it keeps the input vector byte.
- R6: `carry_out` is the carry that leaves lane 3.
- R7: A `reg_idx` of 13 or 15 sets `undef_out`. In that case `vec_out` equals `vec_in` and `carry_out` equals `carry_in`. Any other index clears `undef_out`.
- R8: With `pred` all ones, the output is a 160-bit left shift by s (32 for immediate 0) of the vector zero-extended above, with the low s carry bits ORed in. The low 128 bits form `vec_out` and the top 32 bits form `carry_out`.
- R9: With `pred` all zeros, `vec_out` equals `vec_in` and `carry_out` equals `carry_in`.
- R10: `out_valid` pulses exactly one cycle after each `in_valid` pulse. The data outputs change only in that cycle and otherwise hold their values.
- R11: While `rst` is high at a clock edge, all outputs are cleared to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operands are valid this cycle |
| vec_in | input | 128 | Source and old destination vector |
| carry_in | input | 32 | Scalar carry register value |
| shamt | input | 5 | Shift immediate, 0 means 32 |
| pred | input | 16 | Byte predicate mask |
| reg_idx | input | 4 | Scalar register index |
| out_valid | output | 1 | Result valid, one cycle after in_valid |
| vec_out | output | 128 | Merged result vector |
| carry_out | output | 32 | New scalar carry value |
| undef_out | output | 1 | Undefined-instruction flag |

## Verification
An error in the carry chain shows up in the lanes above the faulty one. It appears in the low bits of those lanes and in `carry_out`, and it is visible in the single cycle after the operation is issued. The bench therefore mixes sparse predicates, in which disabled lanes must pass the carry through, with all-ones predicates that are checked against the independent wide-shift reference. A wrong byte-merge decision corrupts exactly the bytes whose predicate bit differs from the lane-enable bit. Random predicates expose such a fault in the same cycle.

// File: rtl/vshc_pkg.sv
package vshc_pkg;
  localparam int LANE_W_DEF = 32;
  localparam int LANES_DEF  = 4;
  localparam int SH_W_DEF   = 5;
  localparam int IDX_W_DEF  = 4;
  localparam int BYTE_W     = 8;

  // Index values that may not name the carry register
  localparam int BAD_IDX_A = 13;
  localparam int BAD_IDX_B = 15;
endpackage

// File: rtl/vshc_lane.sv
module vshc_lane #(
  parameter int LANE_W = 32,
  parameter int SH_W   = 5
) (
  input  logic [LANE_W-1:0] elem_i,
  input  logic [LANE_W-1:0] cin_i,
  input  logic [SH_W-1:0]   shamt_i,
  input  logic              en_i,
  output logic [LANE_W-1:0] res_o,
  output logic [LANE_W-1:0] cout_o
);
  localparam int DW = 2 * LANE_W;

  logic [SH_W:0]       s_eff;
  logic [DW-1:0]       wide;
  logic [LANE_W-1:0]   low_mask;

  always_comb begin
    // zero immediate encodes a full-lane shift
    s_eff    = (shamt_i == '0) ? (SH_W+1)'(LANE_W) : {1'b0, shamt_i};
    wide     = {{LANE_W{1'b0}}, elem_i} << s_eff;
    low_mask = ~({LANE_W{1'b1}} << s_eff);
    res_o    = wide[LANE_W-1:0] | (cin_i & low_mask);
    cout_o   = en_i ? wide[DW-1:LANE_W] : cin_i;
  end

  always_comb begin
    if (shamt_i == '0) begin
      p_full_shift_r4: assert (res_o == cin_i);
    end
  end
endmodule

// File: rtl/vshc_merge.sv
module vshc_merge #(
  parameter int W      = 128,
  parameter int BYTE_W = 8
) (
  input  logic [W-1:0]        new_i,
  input  logic [W-1:0]        old_i,
  input  logic [W/BYTE_W-1:0] be_i,
  output logic [W-1:0]        out_o
);
  localparam int NB = W / BYTE_W;

  for (genvar b = 0; b < NB; b++) begin : g_byte
    assign out_o[b*BYTE_W +: BYTE_W] = be_i[b] ? new_i[b*BYTE_W +: BYTE_W]
                                               : old_i[b*BYTE_W +: BYTE_W];
  end
endmodule

// File: rtl/vshc_unit.sv
module vshc_unit
  import vshc_pkg::*;
#(
  parameter int LANE_W = LANE_W_DEF,
  parameter int LANES  = LANES_DEF,
  parameter int SH_W   = SH_W_DEF,
  parameter int IDX_W  = IDX_W_DEF,
  localparam int VEC_W  = LANE_W * LANES,
  localparam int PRED_W = VEC_W / BYTE_W,
  localparam int BPL    = LANE_W / BYTE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [VEC_W-1:0]  vec_in,
  input  logic [LANE_W-1:0] carry_in,
  input  logic [SH_W-1:0]   shamt,
  input  logic [PRED_W-1:0] pred,
  input  logic [IDX_W-1:0]  reg_idx,
  output logic              out_valid,
  output logic [VEC_W-1:0]  vec_out,
  output logic [LANE_W-1:0] carry_out,
  output logic              undef_out
);
  logic [LANE_W-1:0] chain [LANES+1];
  logic [VEC_W-1:0]  raw;
  logic [VEC_W-1:0]  merged;
  logic              bad_idx;

  assign chain[0] = carry_in;

  for (genvar e = 0; e < LANES; e++) begin : g_lane
    vshc_lane #(.LANE_W(LANE_W), .SH_W(SH_W)) u_lane (
      .elem_i  (vec_in[e*LANE_W +: LANE_W]),
      .cin_i   (chain[e]),
      .shamt_i (shamt),
      .en_i    (pred[e*BPL]),
      .res_o   (raw[e*LANE_W +: LANE_W]),
      .cout_o  (chain[e+1])
    );
  end

  vshc_merge #(.W(VEC_W), .BYTE_W(BYTE_W)) u_merge (
    .new_i (raw),
    .old_i (vec_in),
    .be_i  (pred),
    .out_o (merged)
  );

  assign bad_idx = (reg_idx == IDX_W'(BAD_IDX_A)) || (reg_idx == IDX_W'(BAD_IDX_B));

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      vec_out   <= '0;
      carry_out <= '0;
      undef_out <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        undef_out <= bad_idx;
        vec_out   <= bad_idx ? vec_in   : merged;
        carry_out <= bad_idx ? carry_in : chain[LANES];
      end
    end
  end

  p_valid_delay_r10: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  p_valid_idle_r10: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> (!out_valid && $stable(vec_out) && $stable(carry_out)));
  p_reject_r7: assert property (@(posedge clk) disable iff (rst)
    (in_valid && bad_idx) |=> (undef_out && vec_out == $past(vec_in)
                               && carry_out == $past(carry_in)));
  p_no_pred_r9: assert property (@(posedge clk) disable iff (rst)
    (in_valid && pred == '0) |=> (vec_out == $past(vec_in)
                                  && carry_out == $past(carry_in)));
endmodule

// File: tb/vshc_unit_test.sv
module vshc_unit_test;
  logic         clk = 0;
  logic         rst;
  logic         in_valid;
  logic [127:0] vec_in;
  logic [31:0]  carry_in;
  logic [4:0]   shamt;
  logic [15:0]  pred;
  logic [3:0]   reg_idx;
  logic         out_valid;
  logic [127:0] vec_out;
  logic [31:0]  carry_out;
  logic         undef_out;

  int n_run = 0;
  int n_fail = 0;
  bit done = 0;

  always #5 clk = ~clk;

  vshc_unit uut (.*);

  function automatic void model(input logic [127:0] v, input logic [31:0] c,
                                input logic [4:0] s, input logic [15:0] p,
                                input logic [3:0] idx,
                                output logic [127:0] vo, output logic [31:0] co,
                                output logic u);
    int sh = (s == 0) ? 32 : int'(s);
    logic [31:0] cur = c;
    logic [127:0] r;
    for (int e = 0; e < 4; e++) begin
      logic [31:0] el = v[e*32 +: 32];
      logic [31:0] m = (sh == 32) ? 32'hFFFF_FFFF : ((32'd1 << sh) - 1);
      logic [31:0] rs = ((sh == 32) ? 32'd0 : (el << sh)) | (cur & m);
      r[e*32 +: 32] = rs;
      if (p[4*e]) cur = (sh == 32) ? el : (el >> (32 - sh));
    end
    for (int b = 0; b < 16; b++) vo[b*8 +: 8] = p[b] ? r[b*8 +: 8] : v[b*8 +: 8];
    co = cur;
    u = (idx == 13) || (idx == 15);
    if (u) begin vo = v; co = c; end
  endfunction

  function automatic logic [159:0] wide_ref(input logic [127:0] v, input logic [31:0] c,
                                            input logic [4:0] s);
    int sh = (s == 0) ? 32 : int'(s);
    logic [159:0] m = (160'd1 << sh) - 1;
    return ({32'd0, v} << sh) | ({128'd0, c} & m);
  endfunction

  task automatic check(input string req, input logic [191:0] act, input logic [191:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic run(input logic [127:0] v, input logic [31:0] c, input logic [4:0] s,
                     input logic [15:0] p, input logic [3:0] idx, input string req);
    logic [127:0] ev; logic [31:0] ec; logic eu;
    model(v, c, s, p, idx, ev, ec, eu);
    @(negedge clk);
    in_valid = 1; vec_in = v; carry_in = c; shamt = s; pred = p; reg_idx = idx;
    @(negedge clk);
    in_valid = 0;
    check({req, " R10 valid"}, {191'd0, out_valid}, 192'd1);
    check(req, {31'd0, undef_out, carry_out, vec_out}, {31'd0, eu, ec, ev});
  endtask

  initial begin
    logic [159:0] w;
    logic [127:0] v; logic [31:0] c;
    rst = 1; in_valid = 0; vec_in = '1; carry_in = '1; shamt = 0; pred = '1; reg_idx = 0;
    repeat (3) @(negedge clk);
    check("R11 reset", {31'd0, undef_out, carry_out, vec_out}, 192'd0);
    check("R11 reset valid", {191'd0, out_valid}, 192'd0);
    rst = 0;

    v = 128'h0123_4567_89AB_CDEF_FEDC_BA98_7654_3210; c = 32'hA5A5_5A5A;
    run(v, c, 5'd4, 16'hFFFF, 4'd2, "R1 R2 R6 shift4");
    run(v, c, 5'd0, 16'hFFFF, 4'd0, "R4 imm0");
    run(v, c, 5'd31, 16'hFFFF, 4'd1, "R1 shift31");
    run(v, c, 5'd1, 16'h0000, 4'd3, "R9 zero pred");
    run(v, c, 5'd8, 16'h0F0F, 4'd4, "R3 lanes 0 2 only");
    run(v, c, 5'd12, 16'hEEEE, 4'd5, "R3 R5 chain off bytes on");
    run(v, c, 5'd12, 16'h1111, 4'd6, "R5 chain on bytes off");
    run(v, c, 5'd7, 16'hFFFF, 4'd13, "R7 idx13");
    run(v, c, 5'd7, 16'hFFFF, 4'd15, "R7 idx15");
    run(v, c, 5'd7, 16'hFFFF, 4'd14, "R7 idx14 allowed");

    // hold check: inputs change without valid
    @(negedge clk);
    vec_in = ~vec_in; carry_in = ~carry_in; reg_idx = 13;
    @(negedge clk);
    check("R10 hold valid", {191'd0, out_valid}, 192'd0);
    begin
      logic [127:0] ev; logic [31:0] ec; logic eu;
      model(v, c, 5'd7, 16'hFFFF, 4'd14, ev, ec, eu);
      check("R10 hold data", {31'd0, undef_out, carry_out, vec_out}, {31'd0, eu, ec, ev});
    end

    void'($urandom(1234));
    for (int i = 0; i < 400; i++) begin
      logic [4:0] s; logic [15:0] p; logic [3:0] idx;
      v = {$urandom, $urandom, $urandom, $urandom}; c = $urandom;
      s = 5'($urandom); idx = 4'($urandom);
      p = (i % 4 == 0) ? 16'hFFFF : 16'($urandom);
      run(v, c, s, p, idx, "R1 R2 R3 R5 R6 random");
      if (p == 16'hFFFF && idx != 13 && idx != 15) begin
        w = wide_ref(v, c, s);
        check("R8 wide ref", {31'd0, 1'b0, carry_out, vec_out}, {31'd0, 1'b0, w});
      end
    end
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog act=hung exp=done");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule